// File: doc/BRIEF.md
# Line-Scan Gradient Edge Flagger

This block sits behind the readout stage of a line-scan camera and marks edge pixels while the stream runs. Pixels are one byte each and arrive with a valid qualifier, a line-start marker on the first pixel and a line-end marker on the last. The block stores the previous scan line in an internal buffer. For each pixel it forms a four-point neighbourhood: the current pixel, its left neighbour, and the two stored pixels directly above them. From these points it computes a gradient magnitude using only adders.

Software may load a new threshold and enable into a staging bank at any time. The settings in use change only once per line. A copy into the working bank happens in the cycle after the line-end pixel, so every pixel of a line sees one consistent set of settings. The block outputs a flag for each pixel two cycles after that pixel is accepted. After the last pixel of a line it also presents the number of edges found in that line, with a strobe.

Top module: `line_edge_det`

## Requirements
- R1: For each accepted pixel (pix_valid=1 at a rising edge), edge_valid is 1 exactly two clock cycles later. edge_valid is 0 in every cycle that does not correspond to an accepted pixel, and pixels come out in arrival order.
- R2: With points A (above-left), B (above), C (left) and D (current), Gx=(D-C)+(B-A) and Gy=(D-B)+(C-A). The magnitude is |Gx|+|Gy|. edge_flag=1 means edge, and it is set when the magnitude is greater than or equal to the working threshold.
- R3: The first pixel of every line (the one marked by pix_sol) is never flagged.
- R4: No pixel of the first line after reset is flagged.
- R5: While the working enable is 0, no pixel is flagged.
- R6: A staging write (cfg_wr=1 at an edge) during a line does not affect that line. Staged values written up to and including the line-end cycle take effect from the next line. A write made in the cycle after line-end or later takes effect one line later still.
- R7: cnt_valid pulses for one cycle together with the edge_valid of a line's last pixel. cnt_value then equals the number of flagged pixels in that line.
- R8: After reset, edge_valid, edge_flag, cnt_valid and cnt_value are all 0. The working enable resets to 0 and the working threshold resets to all ones.
- R9: The block accepts a pixel in every cycle with no stall. This includes a line-start in the cycle right after the previous line-end, and bubbles of invalid cycles inside a line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Pixel qualifier |
| pix_sol | input | 1 | First pixel of a line |
| pix_eol | input | 1 | Last pixel of a line |
| pix_data | input | 8 | Pixel intensity |
| cfg_wr | input | 1 | Staging bank write strobe |
| cfg_en | input | 1 | Staged edge enable |
| cfg_thr | input | 10 | Staged gradient threshold |
| edge_valid | output | 1 | Flag qualifier, two cycles after the pixel |
| edge_flag | output | 1 | 1 when the pixel is an edge |
| cnt_valid | output | 1 | Line edge count strobe |
| cnt_value | output | clog2(LINE_LEN+1) | Edges in the finished line |

## Verification
Random-intensity lines check the gradient arithmetic across all sign combinations of Gx and Gy. Flat lines and single-step lines separate a correct zero magnitude from a stray flag. A lone spike on a zero line gives a known magnitude of 200, and thresholds of 200 and 201 bracket the greater-or-equal boundary. Extreme thresholds of 0 and all ones show whether the first-column and first-line exclusions hold even when every other pixel would be flagged or none would. Settings written mid-line, in the copy cycle and in the gap show whether the switch happens exactly at the line boundary. Back-to-back lines and in-line bubbles show that the stored line and the above-left history stay aligned.

// File: rtl/lsed_pkg.sv
package lsed_pkg;
    localparam int PIX_W = 8;
    localparam int MAG_W = PIX_W + 2;
    typedef logic [PIX_W-1:0] pix_t;
    typedef logic [MAG_W-1:0] mag_t;
    typedef struct packed {
        logic en;
        mag_t thr;
    } cfg_t;
endpackage

// File: rtl/lsed_linebuf.sv
module lsed_linebuf
    import lsed_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  pix_t          wdata_i,
    output pix_t          rdata_o
);
    pix_t mem [DEPTH];
    pix_t rd_q;

    // read returns the stored (previous line) value before the overwrite
    always_ff @(posedge clk) begin
        if (we_i) begin
            mem[addr_i] <= wdata_i;
            rd_q        <= mem[addr_i];
        end
    end

    assign rdata_o = rd_q;
endmodule

// File: rtl/lsed_shadow.sv
module lsed_shadow
    import lsed_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_i,
    input  cfg_t wr_cfg_i,
    input  logic copy_i,
    output cfg_t act_o
);
    typedef struct packed {
        cfg_t stage;
        cfg_t act;
    } st_t;

    localparam cfg_t CFG_RST = '{en: 1'b0, thr: '1};

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i)   st_d.stage = wr_cfg_i;
        if (copy_i) st_d.act   = st_q.stage;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{stage: CFG_RST, act: CFG_RST};
        else        st_q <= st_d;
    end

    assign act_o = st_q.act;

    // R6: working settings move only on a copy cycle
    p_hold_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !copy_i |=> $stable(act_o));
endmodule

// File: rtl/lsed_kernel.sv
module lsed_kernel
    import lsed_pkg::*;
#(
    parameter int LINE_LEN = 1024,
    parameter int CNT_W    = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sol,
    input  logic             in_eol,
    input  logic             in_ok,
    input  pix_t             in_pix,
    input  pix_t             above_i,
    input  cfg_t             cfg_i,
    output logic             ev_o,
    output logic             ef_o,
    output logic             cv_o,
    output logic [CNT_W-1:0] cnt_o
);
    typedef struct packed {
        logic v;
        logic sol;
        logic eol;
        logic ok;
        pix_t cur;
        pix_t left;
        pix_t al;
    } s1_t;

    typedef struct packed {
        logic             ev;
        logic             ef;
        logic             cv;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] acc;
    } s2_t;

    typedef logic signed [PIX_W+2:0] sg_t;

    s1_t s1_d, s1_q;
    s2_t s2_d, s2_q;
    sg_t pa, pb, pc, pd, gx, gy, ax, ay;
    mag_t mag;
    logic hit;
    logic [CNT_W-1:0] base, sum;

    always_comb begin
        s1_d     = s1_q;
        s1_d.v   = in_valid;
        s1_d.sol = in_valid & in_sol;
        s1_d.eol = in_valid & in_eol;
        if (in_valid) begin
            s1_d.ok   = in_ok;
            s1_d.cur  = in_pix;
            s1_d.left = s1_q.cur;
            s1_d.al   = above_i;
        end

        pa = sg_t'({3'b000, s1_q.al});
        pb = sg_t'({3'b000, above_i});
        pc = sg_t'({3'b000, s1_q.left});
        pd = sg_t'({3'b000, s1_q.cur});
        gx = (pd - pc) + (pb - pa);
        gy = (pd - pb) + (pc - pa);
        ax = gx[PIX_W+2] ? -gx : gx;
        ay = gy[PIX_W+2] ? -gy : gy;
        mag = mag_t'(ax + ay);
        hit = s1_q.v & s1_q.ok & cfg_i.en & (mag >= cfg_i.thr);

        base = s1_q.sol ? '0 : s2_q.acc;
        sum  = base + CNT_W'(hit);

        s2_d    = s2_q;
        s2_d.ev = s1_q.v;
        s2_d.ef = hit;
        s2_d.cv = s1_q.v & s1_q.eol;
        if (s1_q.v) s2_d.acc = sum;
        if (s1_q.v && s1_q.eol) s2_d.cnt = sum;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign ev_o  = s2_q.ev;
    assign ef_o  = s2_q.ef;
    assign cv_o  = s2_q.cv;
    assign cnt_o = s2_q.cnt;

    // R3: a line-start pixel in stage one never yields a flag
    p_first_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_q.v && s1_q.sol) |=> !ef_o);
    // R5: disabled settings give no flag
    p_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_q.v && !cfg_i.en) |=> !ef_o);
    // R7: a line cannot hold more edges than pixels
    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cv_o |-> (int'(cnt_o) <= LINE_LEN));
endmodule

// File: rtl/line_edge_det.sv
module line_edge_det
    import lsed_pkg::*;
#(
    parameter int LINE_LEN = 1024,
    localparam int CNT_W   = $clog2(LINE_LEN + 1),
    localparam int ADDR_W  = $clog2(LINE_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_valid,
    input  logic             pix_sol,
    input  logic             pix_eol,
    input  logic [PIX_W-1:0] pix_data,
    input  logic             cfg_wr,
    input  logic             cfg_en,
    input  logic [MAG_W-1:0] cfg_thr,
    output logic             edge_valid,
    output logic             edge_flag,
    output logic             cnt_valid,
    output logic [CNT_W-1:0] cnt_value
);
    typedef struct packed {
        logic [ADDR_W-1:0] col;
        logic              have;
        logic              copy;
    } s0_t;

    s0_t s0_d, s0_q;
    logic [ADDR_W-1:0] col_now;
    pix_t above;
    cfg_t act_cfg;
    cfg_t wr_cfg;

    always_comb begin
        col_now   = pix_sol ? '0 : s0_q.col;
        s0_d      = s0_q;
        s0_d.copy = pix_valid & pix_eol;
        if (pix_valid) begin
            s0_d.col = col_now + 1'b1;
            if (pix_eol) s0_d.have = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s0_q <= '0;
        else        s0_q <= s0_d;
    end

    assign wr_cfg = '{en: cfg_en, thr: cfg_thr};

    lsed_linebuf #(.DEPTH(LINE_LEN)) u_buf (
        .clk     (clk),
        .we_i    (pix_valid),
        .addr_i  (col_now),
        .wdata_i (pix_data),
        .rdata_o (above)
    );

    lsed_shadow u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (cfg_wr),
        .wr_cfg_i (wr_cfg),
        .copy_i   (s0_q.copy),
        .act_o    (act_cfg)
    );

    lsed_kernel #(.LINE_LEN(LINE_LEN), .CNT_W(CNT_W)) u_kernel (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (pix_valid),
        .in_sol   (pix_sol),
        .in_eol   (pix_eol),
        .in_ok    (s0_q.have & ~pix_sol),
        .in_pix   (pix_data),
        .above_i  (above),
        .cfg_i    (act_cfg),
        .ev_o     (edge_valid),
        .ef_o     (edge_flag),
        .cv_o     (cnt_valid),
        .cnt_o    (cnt_value)
    );

    // R1: fixed two-cycle latency from accepted pixel to flag
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |=> ##1 edge_valid);
    p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |=> ##1 !edge_valid);
endmodule

// File: tb/line_edge_det_tb.sv
module line_edge_det_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LL = 32;
    localparam int CW = $clog2(LL + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_valid = 1'b0, pix_sol = 1'b0, pix_eol = 1'b0;
    logic [7:0] pix_data = '0;
    logic cfg_wr = 1'b0, cfg_en = 1'b0;
    logic [9:0] cfg_thr = '0;
    logic edge_valid, edge_flag, cnt_valid;
    logic [CW-1:0] cnt_value;

    line_edge_det #(.LINE_LEN(LL)) u_dut (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sol(pix_sol),
        .pix_eol(pix_eol), .pix_data(pix_data), .cfg_wr(cfg_wr), .cfg_en(cfg_en),
        .cfg_thr(cfg_thr), .edge_valid(edge_valid), .edge_flag(edge_flag),
        .cnt_valid(cnt_valid), .cnt_value(cnt_value)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0;
    int prev_line[LL], cur_line[LL];
    bit have_m = 0;
    bit st_en = 0, act_en = 0;
    int st_thr = 1023, act_thr = 1023;
    int line_cnt = 0;
    bit exp_f[$];
    string exp_t[$];
    int exp_c[$];
    logic [1:0] vh = '0, eh = '0;
    bit mon_on = 0;

    always @(posedge clk) begin
        vh <= {vh[0], pix_valid};
        eh <= {eh[0], pix_valid & pix_eol};
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int iabs(input int v);
        return v < 0 ? -v : v;
    endfunction

    function automatic int grad(input int a, input int b, input int c, input int d);
        return iabs((d - c) + (b - a)) + iabs((d - b) + (c - a));
    endfunction

    always @(negedge clk) begin
        if (mon_on) begin
            chk(edge_valid == vh[1], "R1 edge_valid timing", edge_valid, vh[1]);
            if (edge_valid) begin
                if (exp_f.size() == 0) chk(0, "R1 unexpected output", 1, 0);
                else begin
                    bit f;
                    string t;
                    f = exp_f.pop_front();
                    t = exp_t.pop_front();
                    chk(edge_flag == f, t, edge_flag, f);
                end
            end
            chk(cnt_valid == (vh[1] & eh[1]), "R7 count strobe", cnt_valid, vh[1] & eh[1]);
            if (cnt_valid) begin
                if (exp_c.size() == 0) chk(0, "R7 unexpected count", 1, 0);
                else begin
                    int c;
                    c = exp_c.pop_front();
                    chk(int'(cnt_value) == c, "R7 count value", int'(cnt_value), c);
                end
            end
        end
    end

    task automatic drive_pix(input int col, input int val, input bit r6, input bit r9,
                             input bit wr, input bit wen, input int wthr);
        bit f;
        string t;
        @(negedge clk);
        pix_valid = 1'b1;
        pix_sol   = (col == 0);
        pix_eol   = (col == LL - 1);
        pix_data  = 8'(val);
        cfg_wr    = wr;
        cfg_en    = wen;
        cfg_thr   = 10'(wthr);
        if (wr) begin st_en = wen; st_thr = wthr; end
        if (!have_m) begin f = 0; t = "R4 first line"; end
        else if (col == 0) begin f = 0; t = "R3 first pixel"; end
        else begin
            f = act_en && (grad(prev_line[col-1], prev_line[col], cur_line[col-1], val) >= act_thr);
            if (!act_en) t = "R5 disabled";
            else if (r6) t = "R6 staging";
            else if (r9) t = "R9 back-to-back";
            else t = "R2 gradient";
        end
        exp_f.push_back(f);
        exp_t.push_back(t);
        cur_line[col] = val;
        line_cnt = (col == 0 ? 0 : line_cnt) + int'(f);
        if (col == LL - 1) begin
            exp_c.push_back(line_cnt);
            prev_line = cur_line;
            have_m = 1;
            act_en = st_en;
            act_thr = st_thr;
        end
    endtask

    task automatic idle(input bit wr, input bit wen, input int wthr);
        @(negedge clk);
        pix_valid = 1'b0; pix_sol = 1'b0; pix_eol = 1'b0;
        cfg_wr = wr; cfg_en = wen; cfg_thr = 10'(wthr);
        if (wr) begin st_en = wen; st_thr = wthr; end
    endtask

    // kind: 0 random, 1 constant, 2 step, 3 spike, 4 zeros
    task automatic send_line(input int kind, input bit bubbles, input bit r6, input bit r9,
                             input int mcol, input bit mwen, input int mwthr);
        for (int c = 0; c < LL; c++) begin
            int v;
            if (bubbles && c != 0 && ($urandom % 6) == 0) idle(0, 0, 0);
            case (kind)
                0: v = $urandom % 256;
                1: v = 50;
                2: v = (c < LL/2) ? 0 : 200;
                3: v = (c == 10) ? 100 : 0;
                default: v = 0;
            endcase
            drive_pix(c, v, r6, r9, c == mcol, mwen, mwthr);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state
        chk(edge_valid == 0, "R8 reset edge_valid", edge_valid, 0);
        chk(edge_flag == 0, "R8 reset edge_flag", edge_flag, 0);
        chk(cnt_valid == 0, "R8 reset cnt_valid", cnt_valid, 0);
        chk(int'(cnt_value) == 0, "R8 reset cnt_value", int'(cnt_value), 0);
        mon_on = 1;
        // staged before line 0: threshold 0, enable on (line 0 stays unflagged, R4)
        idle(1, 1, 0);
        idle(0, 0, 0);
        send_line(0, 0, 0, 0, -1, 0, 0);
        idle(0, 0, 0); idle(0, 0, 0);
        // threshold 0: every pixel but column 0 flagged (R2, R3)
        send_line(0, 0, 0, 0, -1, 0, 0);
        idle(0, 0, 0);
        // mid-line write of threshold 1023 does not affect this line (R6)
        send_line(0, 0, 1, 0, 5, 1, 1023);
        idle(0, 0, 0);
        send_line(0, 0, 1, 0, -1, 0, 0);
        // copy-cycle write goes to the line after next (R6)
        idle(1, 0, 0);
        idle(0, 0, 0);
        send_line(0, 0, 1, 0, -1, 0, 0);
        idle(0, 0, 0);
        send_line(0, 0, 0, 0, -1, 0, 0);  // R5: enable now 0
        idle(0, 0, 0);
        idle(1, 1, 200);
        send_line(4, 0, 0, 0, -1, 0, 0);
        idle(0, 0, 0);
        send_line(3, 0, 0, 0, -1, 0, 0);  // spike: magnitude 200 meets threshold 200
        idle(0, 0, 0);
        idle(1, 1, 201);
        send_line(4, 0, 0, 0, -1, 0, 0);
        idle(0, 0, 0);
        send_line(3, 0, 0, 0, -1, 0, 0);  // magnitude 200 below 201
        idle(0, 0, 0);
        // back-to-back lines with threshold 0 (R9)
        idle(1, 1, 0);
        send_line(2, 0, 0, 1, -1, 0, 0);
        send_line(0, 0, 0, 1, -1, 0, 0);
        send_line(1, 0, 0, 1, 7, 1, 40);
        send_line(0, 1, 0, 1, -1, 0, 0);
        // random lines
        for (int n = 0; n < 40; n++) begin
            int kind, gap, mcol, thr;
            bit wen;
            kind = $urandom % 5;
            gap  = $urandom % 4;
            mcol = (($urandom % 3) == 0) ? int'($urandom % LL) : -1;
            case ($urandom % 4)
                0: thr = 0;
                1: thr = 1023;
                default: thr = $urandom % 400;
            endcase
            wen = ($urandom % 5) != 0;
            send_line(kind, ($urandom % 2) == 1, mcol >= 0, gap == 0, mcol, wen, thr);
            for (int g = 0; g < gap; g++) begin
                if (($urandom % 3) == 0) idle(1, ($urandom % 5) != 0, $urandom % 400);
                else idle(0, 0, 0);
            end
        end
        repeat (6) idle(0, 0, 0);
        chk(exp_f.size() == 0, "R1 all flags delivered", exp_f.size(), 0);
        chk(exp_c.size() == 0, "R7 all counts delivered", exp_c.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule